// File: doc/BRIEF.md
# Operand Effective Address Generator

This block works out where one instruction operand lives for a 64-bit accumulator-style processor. A caller supplies an addressing-mode code, the instruction prefix and extension-prefix bytes, the X, Y and E registers and a program counter that already points at the operand bytes. It then pulses `start_i`. The block reads the operand address bytes through a byte-wide synchronous memory port. The number of bytes depends on the prefix. If the mode is indirect, it then reads an 8-byte pointer. It applies X or Y indexing before or after the pointer read, as the mode requires.

When the address is ready, the block pulses `done_o` for one cycle. It presents the effective address, the program counter advanced past the consumed operand bytes, and the internal address-size code. All three outputs hold until the next completion. Modes that need no memory access (immediate, E-register indirect, implied) complete one cycle after the start.

The memory port returns `mem_rdata_i` one cycle after the cycle in which `mem_req_o` was high with `mem_addr_o`. Byte reads are issued back to back.

Top module: `eaddr_gen`

## Requirements
- R1: For the zero-page family of modes, the size code is chosen from prefix bits [3:2]: selector 0 gives 0, 1 gives 1, 2 gives 5 and 3 gives 3. The zero-page family is mode codes 2 (direct), 3 (+X), 4 (+Y), 5 (indirect), 6 (X then pointer) and 7 (pointer then Y). The block reads code+1 bytes starting at the PC, assembles them little-endian, and returns PC + code + 1.
- R2: For the absolute family of modes, the size code is chosen from prefix bits [3:2]: selector 0 gives 0, 1 gives 1, 2 gives 6 and 3 gives 7. The absolute family is mode codes 8 (direct), 9 (+X), 10 (+Y), 11 (indirect), 12 (X then pointer) and 13 (pointer then Y). Bytes and PC are handled as in R1.
- R3: Any mode outside both families (0, 1, 14, 15) reports size code 8'hFF on `asz_o`.
- R4: Modes 3 and 9 add X to the fetched address, and modes 4 and 10 add Y.
- R5: Modes 5 and 11 read an 8-byte little-endian pointer at the fetched address, and the pointer is the result.
- R6: Modes 6 and 12 read the pointer at the fetched address plus X. Modes 7 and 13 read the pointer at the fetched address and add Y to it.
- R7: Mode 14 returns `e_i` with the PC unchanged and issues no memory request.
- R8: Mode 1 (immediate) returns the PC as the address and advances the PC by 1 << prefix[5:4].
- R9: For a shift or rotate immediate (`imm_shift_i`=1), the PC advances by exactly 1 unless the alternate table is active. The alternate table is active when (ext_prefix[3:0] & 4'hD) == 4'hD and ext_prefix[7:4] == 0; in that case R8 applies.
- R10: `done_o` is high for exactly one cycle per operation. `ea_o`, `pc_o` and `asz_o` change only when it rises.
- R11: A `start_i` received while an operation is in progress is ignored.
- R12: After reset, `done_o`, `mem_req_o`, `ea_o`, `pc_o` and `asz_o` are all zero.
- R13: Modes 0 (implied) and 15 (reserved) return address 0 with the PC unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| mode_i | input | 4 | Addressing-mode code |
| prefix_i | input | 8 | Prefix byte; [3:2] address size, [5:4] immediate size |
| ext_prefix_i | input | 8 | Extension prefix byte |
| imm_shift_i | input | 1 | Instruction is a shift/rotate with immediate count |
| x_i | input | 64 | X index register |
| y_i | input | 64 | Y index register |
| e_i | input | 64 | E register |
| pc_i | input | 64 | Address of the first operand byte |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | 64 | Byte read address |
| mem_rdata_i | input | 8 | Read data, one cycle after the request |
| ea_o | output | 64 | Effective address |
| pc_o | output | 64 | Program counter after the operand |
| asz_o | output | 8 | Address size code of the last operation |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The hardest case to reach is a second start that arrives while the pointer or address bytes are still streaming in. The outputs must reflect only the first request, and the memory port must not be restarted. The bench launches an 8-byte absolute fetch and, a few cycles later, pulses start again with an E-indirect request carrying a different PC. It then checks the completed address, the read count and that only one strobe appears. The alternate-table rule is reached by pairing shift immediates with extension bytes that match and that just miss the mask.

// File: rtl/eaddr_pkg.sv
package eaddr_pkg;
  localparam logic [3:0] M_IMPL  = 4'd0;
  localparam logic [3:0] M_IMM   = 4'd1;
  localparam logic [3:0] M_ZP    = 4'd2;
  localparam logic [3:0] M_ZPX   = 4'd3;
  localparam logic [3:0] M_ZPY   = 4'd4;
  localparam logic [3:0] M_ZIND  = 4'd5;
  localparam logic [3:0] M_ZINDX = 4'd6;
  localparam logic [3:0] M_ZINDY = 4'd7;
  localparam logic [3:0] M_AB    = 4'd8;
  localparam logic [3:0] M_ABX   = 4'd9;
  localparam logic [3:0] M_ABY   = 4'd10;
  localparam logic [3:0] M_AIND  = 4'd11;
  localparam logic [3:0] M_AINDX = 4'd12;
  localparam logic [3:0] M_AINDY = 4'd13;
  localparam logic [3:0] M_EREG  = 4'd14;

  typedef enum logic [1:0] {S_IDLE, S_OPND, S_PTR} eag_state_e;

  function automatic logic is_zp(logic [3:0] m);
    return (m >= M_ZP) && (m <= M_ZINDY);
  endfunction

  function automatic logic is_ab(logic [3:0] m);
    return (m >= M_AB) && (m <= M_AINDY);
  endfunction

  function automatic logic is_ind(logic [3:0] m);
    return m inside {M_ZIND, M_ZINDX, M_ZINDY, M_AIND, M_AINDX, M_AINDY};
  endfunction

  function automatic logic uses_x(logic [3:0] m);
    return m inside {M_ZPX, M_ABX, M_ZINDX, M_AINDX};
  endfunction

  function automatic logic uses_y(logic [3:0] m);
    return m inside {M_ZPY, M_ABY, M_ZINDY, M_AINDY};
  endfunction

  // index applied to the pointer rather than to the fetched address
  function automatic logic post_idx(logic [3:0] m);
    return m inside {M_ZINDY, M_AINDY};
  endfunction
endpackage

// File: rtl/eaddr_size_dec.sv
module eaddr_size_dec
  import eaddr_pkg::*;
(
  input  logic [3:0] mode_i,
  input  logic [1:0] sel_i,
  output logic [7:0] code_o
);
  always_comb begin
    code_o = 8'hFF;
    if (is_zp(mode_i)) begin
      unique case (sel_i)
        2'd0: code_o = 8'd0;
        2'd1: code_o = 8'd1;
        2'd2: code_o = 8'd5;
        2'd3: code_o = 8'd3;
      endcase
    end else if (is_ab(mode_i)) begin
      unique case (sel_i)
        2'd0: code_o = 8'd0;
        2'd1: code_o = 8'd1;
        2'd2: code_o = 8'd6;
        2'd3: code_o = 8'd7;
      endcase
    end
  end
endmodule

// File: rtl/eaddr_fetch.sv
module eaddr_fetch #(
  parameter int AW   = 64,
  parameter int MAXB = 8,
  localparam int CW  = $clog2(MAXB),
  localparam int VW  = MAXB * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] last_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  input  logic [7:0]    rdata_i,
  output logic [VW-1:0] val_o,
  output logic          done_o
);
  logic          busy_q, rv_q, done_q;
  logic [CW:0]   iss_q;
  logic [CW-1:0] cap_q, last_q;
  logic [AW-1:0] base_q;
  logic [VW-1:0] val_q;

  assign req_o  = busy_q && (iss_q <= {1'b0, last_q});
  assign addr_o = base_q + AW'(iss_q);
  assign val_o  = val_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rv_q   <= 1'b0;
      done_q <= 1'b0;
      iss_q  <= '0;
      cap_q  <= '0;
      last_q <= '0;
      base_q <= '0;
      val_q  <= '0;
    end else begin
      done_q <= 1'b0;
      rv_q   <= req_o;
      if (go_i) begin
        busy_q <= 1'b1;
        iss_q  <= '0;
        cap_q  <= '0;
        last_q <= last_i;
        base_q <= base_i;
        val_q  <= '0;
      end else begin
        if (req_o) iss_q <= iss_q + 1'b1;
        if (rv_q) begin
          val_q[{cap_q, 3'b000} +: 8] <= rdata_i;  // little-endian assembly
          cap_q <= cap_q + 1'b1;
          if (cap_q == last_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  AST_GO_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !busy_q);  // R11
  AST_ADDR_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && iss_q != '0) |-> addr_o == $past(addr_o) + 1'b1);  // R1
endmodule

// File: rtl/eaddr_gen.sv
module eaddr_gen
  import eaddr_pkg::*;
#(
  parameter int AW        = 64,
  parameter int PTR_BYTES = 8,
  localparam int CW       = $clog2(PTR_BYTES),
  localparam int VW       = PTR_BYTES * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    mode_i,
  input  logic [7:0]    prefix_i,
  input  logic [7:0]    ext_prefix_i,
  input  logic          imm_shift_i,
  input  logic [AW-1:0] x_i,
  input  logic [AW-1:0] y_i,
  input  logic [AW-1:0] e_i,
  input  logic [AW-1:0] pc_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_rdata_i,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] pc_o,
  output logic [7:0]    asz_o,
  output logic          done_o
);
  eag_state_e    state_q;
  logic [3:0]    mode_q;
  logic [AW-1:0] x_q, y_q, pcn_q, ea_q, pc_out_q;
  logic [7:0]    asz_c, asz_q, asz_out_q;
  logic          done_q;

  logic          f_go, f_done;
  logic [AW-1:0] f_base;
  logic [CW-1:0] f_last;
  logic [VW-1:0] f_val;
  logic [AW-1:0] idx_q, addr_idx, ptr_idx, imm_len;
  logic          alt_tbl;

  eaddr_size_dec u_size (
    .mode_i (mode_i),
    .sel_i  (prefix_i[3:2]),
    .code_o (asz_c)
  );

  eaddr_fetch #(.AW(AW), .MAXB(PTR_BYTES)) u_fetch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (f_go),
    .base_i  (f_base),
    .last_i  (f_last),
    .req_o   (mem_req_o),
    .addr_o  (mem_addr_o),
    .rdata_i (mem_rdata_i),
    .val_o   (f_val),
    .done_o  (f_done)
  );

  assign alt_tbl  = ((ext_prefix_i[3:0] & 4'hD) == 4'hD) && (ext_prefix_i[7:4] == 4'h0);
  assign imm_len  = (imm_shift_i && !alt_tbl) ? AW'(1) : (AW'(1) << prefix_i[5:4]);
  assign idx_q    = uses_x(mode_q) ? x_q : y_q;
  assign addr_idx = AW'(f_val) + (((uses_x(mode_q) || uses_y(mode_q)) && !post_idx(mode_q)) ? idx_q : '0);
  assign ptr_idx  = AW'(f_val) + (post_idx(mode_q) ? y_q : '0);

  always_comb begin
    f_go   = 1'b0;
    f_base = pc_i;
    f_last = asz_c[CW-1:0];
    if (state_q == S_IDLE && start_i && (is_zp(mode_i) || is_ab(mode_i))) begin
      f_go = 1'b1;
    end else if (state_q == S_OPND && f_done && is_ind(mode_q)) begin
      f_go   = 1'b1;
      f_base = addr_idx;
      f_last = CW'(PTR_BYTES - 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      mode_q    <= '0;
      x_q       <= '0;
      y_q       <= '0;
      pcn_q     <= '0;
      asz_q     <= '0;
      ea_q      <= '0;
      pc_out_q  <= '0;
      asz_out_q <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          mode_q <= mode_i;
          x_q    <= x_i;
          y_q    <= y_i;
          asz_q  <= asz_c;
          pcn_q  <= pc_i + AW'(asz_c[CW-1:0]) + AW'(1);
          if (is_zp(mode_i) || is_ab(mode_i)) begin
            state_q <= S_OPND;
          end else begin
            done_q    <= 1'b1;
            asz_out_q <= asz_c;
            case (mode_i)
              M_IMM:   begin ea_q <= pc_i; pc_out_q <= pc_i + imm_len; end
              M_EREG:  begin ea_q <= e_i;  pc_out_q <= pc_i; end
              default: begin ea_q <= '0;   pc_out_q <= pc_i; end
            endcase
          end
        end
        S_OPND: if (f_done) begin
          if (is_ind(mode_q)) begin
            state_q <= S_PTR;
          end else begin
            state_q   <= S_IDLE;
            ea_q      <= addr_idx;
            pc_out_q  <= pcn_q;
            asz_out_q <= asz_q;
            done_q    <= 1'b1;
          end
        end
        S_PTR: if (f_done) begin
          state_q   <= S_IDLE;
          ea_q      <= ptr_idx;
          pc_out_q  <= pcn_q;
          asz_out_q <= asz_q;
          done_q    <= 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ea_o   = ea_q;
  assign pc_o   = pc_out_q;
  assign asz_o  = asz_out_q;
  assign done_o = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R10
  AST_PC_ONLY_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pc_o) |-> done_o);  // R10
  AST_EREG_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && start_i && mode_i == M_EREG) |=> (done_o && ea_o == $past(e_i)));  // R7
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE) |-> !mem_req_o);  // R7
endmodule

// File: tb/eaddr_gen_tb.sv
module eaddr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  pre = '0, ext = '0;
  logic        sh = 1'b0;
  logic [63:0] xr = '0, yr = '0, er = '0, pcr = '0;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [63:0] ea, pco;
  logic [7:0]  asz;
  logic        done;

  logic [7:0] mem [256];
  int checks = 0, fails = 0, req_cnt = 0, cyc = 0, done_cnt = 0;

  always #4 clk = ~clk;  // 125 MHz

  eaddr_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .prefix_i(pre),
    .ext_prefix_i(ext), .imm_shift_i(sh), .x_i(xr), .y_i(yr), .e_i(er), .pc_i(pcr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .ea_o(ea), .pc_o(pco), .asz_o(asz), .done_o(done)
  );

  always_ff @(posedge clk) begin
    if (mem_req) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_req) req_cnt <= req_cnt + 1;
    if (done) done_cnt <= done_cnt + 1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  typedef struct packed {
    logic [3:0] m; logic [7:0] p; logic [7:0] x; logic s; logic [7:0] dpc; logic [7:0] az;
  } vec_t;
  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  8'h00, 8'h00, 1'b0, 8'd1, 8'h00},
    '{4'd2,  8'h04, 8'h00, 1'b0, 8'd2, 8'h01},
    '{4'd2,  8'h08, 8'h00, 1'b0, 8'd6, 8'h05},
    '{4'd2,  8'h0C, 8'h00, 1'b0, 8'd4, 8'h03},
    '{4'd8,  8'h08, 8'h00, 1'b0, 8'd7, 8'h06},
    '{4'd8,  8'h0C, 8'h00, 1'b0, 8'd8, 8'h07},
    '{4'd3,  8'h0C, 8'h00, 1'b0, 8'd4, 8'h03},
    '{4'd4,  8'h04, 8'h00, 1'b0, 8'd2, 8'h01},
    '{4'd5,  8'h04, 8'h00, 1'b0, 8'd2, 8'h01},
    '{4'd6,  8'h04, 8'h00, 1'b0, 8'd2, 8'h01},
    '{4'd7,  8'h04, 8'h00, 1'b0, 8'd2, 8'h01},
    '{4'd9,  8'h0C, 8'h00, 1'b0, 8'd8, 8'h07},
    '{4'd10, 8'h08, 8'h00, 1'b0, 8'd7, 8'h06},
    '{4'd11, 8'h0C, 8'h00, 1'b0, 8'd8, 8'h07},
    '{4'd12, 8'h08, 8'h00, 1'b0, 8'd7, 8'h06},
    '{4'd13, 8'h0C, 8'h00, 1'b0, 8'd8, 8'h07},
    '{4'd14, 8'h0C, 8'h00, 1'b0, 8'd0, 8'hFF},
    '{4'd1,  8'h30, 8'h00, 1'b0, 8'd8, 8'hFF},
    '{4'd1,  8'h10, 8'h00, 1'b0, 8'd2, 8'hFF},
    '{4'd1,  8'h20, 8'h00, 1'b1, 8'd1, 8'hFF},
    '{4'd1,  8'h20, 8'h0D, 1'b1, 8'd4, 8'hFF},
    '{4'd1,  8'h20, 8'h1D, 1'b1, 8'd1, 8'hFF},
    '{4'd1,  8'h10, 8'h0F, 1'b1, 8'd2, 8'hFF},
    '{4'd0,  8'h0C, 8'h00, 1'b0, 8'd0, 8'hFF},
    '{4'd15, 8'h08, 8'h00, 1'b0, 8'd0, 8'hFF}
  };

  function automatic int nbytes(logic [3:0] m, logic [7:0] p);
    int zp_t [4] = '{1, 2, 6, 4};
    int ab_t [4] = '{1, 2, 7, 8};
    if (m >= 2 && m <= 7) return zp_t[p[3:2]];
    if (m >= 8 && m <= 13) return ab_t[p[3:2]];
    return 0;
  endfunction

  function automatic logic [63:0] rd(logic [63:0] a, int n);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) r[i*8 +: 8] = mem[8'(a + 64'(i))];
    return r;
  endfunction

  function automatic logic [63:0] model_ea(logic [3:0] m, logic [7:0] p, logic [63:0] pc,
                                           logic [63:0] x, logic [63:0] y, logic [63:0] e);
    logic [63:0] a = rd(pc, nbytes(m, p));
    case (m)
      4'd2, 4'd8:   return a;
      4'd3, 4'd9:   return a + x;
      4'd4, 4'd10:  return a + y;
      4'd5, 4'd11:  return rd(a, 8);
      4'd6, 4'd12:  return rd(a + x, 8);
      4'd7, 4'd13:  return rd(a, 8) + y;
      4'd14:        return e;
      4'd1:         return pc;
      default:      return '0;
    endcase
  endfunction

  function automatic string tag(logic [3:0] m, logic s);
    case (m)
      4'd2: return "R1";
      4'd8: return "R2";
      4'd3, 4'd4, 4'd9, 4'd10: return "R4";
      4'd5, 4'd11: return "R5";
      4'd6, 4'd7, 4'd12, 4'd13: return "R6";
      4'd14: return "R7";
      4'd1: return s ? "R9" : "R8";
      default: return "R13";
    endcase
  endfunction

  task automatic chk(string r, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    int n = 0;
    ok = 1'b0;
    while (n < 200) begin
      if (done === 1'b1) begin ok = 1'b1; break; end
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_op(logic [3:0] m, logic [7:0] p, logic [7:0] x_, logic s, string r);
    bit ok;
    @(negedge clk);
    mode = m; pre = p; ext = x_; sh = s; start = 1'b1;
    req_cnt = 0;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    if (!ok) chk(r, "done timeout", 64'd0, 64'd1);
  endtask

  initial begin
    bit ok;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 29 + 7);
    xr = 64'h3; yr = 64'h5; er = 64'hDEAD_BEEF_0000_1234; pcr = 64'h10;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "done", 64'(done), 64'd0);
    chk("R12", "mem_req", 64'(mem_req), 64'd0);
    chk("R12", "ea", ea, 64'd0);
    chk("R12", "pc", pco, 64'd0);
    chk("R12", "asz", 64'(asz), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      vec_t t = VEC[v];
      string r = tag(t.m, t.s);
      run_op(t.m, t.p, t.x, t.s, r);
      chk(r, "ea", ea, model_ea(t.m, t.p, pcr, xr, yr, er));
      chk(r, "pc", pco, pcr + 64'(t.dpc));
      chk((t.az == 8'hFF) ? "R3" : r, "asz", 64'(asz), 64'(t.az));
      if (t.m == 4'd14 || t.m == 4'd1 || t.m == 4'd0)
        chk(r, "memory requests", 64'(req_cnt), 64'd0);
      @(negedge clk);
      // R10: strobe is one cycle and outputs hold
      chk("R10", "done width", 64'(done), 64'd0);
      chk("R10", "ea hold", ea, model_ea(t.m, t.p, pcr, xr, yr, er));
    end

    // R11: second start during an 8-byte absolute fetch is ignored
    @(negedge clk);
    mode = 4'd8; pre = 8'h0C; ext = 8'h00; sh = 1'b0; start = 1'b1;
    req_cnt = 0; done_cnt = 0;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    mode = 4'd14; pcr = 64'h40; start = 1'b1;
    @(negedge clk);
    start = 1'b0; mode = 4'd8; pcr = 64'h10;
    wait_done(ok);
    chk("R11", "completed", 64'(ok), 64'd1);
    chk("R11", "ea", ea, model_ea(4'd8, 8'h0C, 64'h10, xr, yr, er));
    chk("R11", "pc", pco, 64'h18);
    repeat (6) @(negedge clk);
    chk("R11", "read count", 64'(req_cnt), 64'd8);
    chk("R11", "strobes", 64'(done_cnt), 64'd1);

    // R6: pointer-then-Y with large Y and X then pointer with a different X
    xr = 64'h21; yr = 64'h1_0000_0000;
    run_op(4'd13, 8'h08, 8'h00, 1'b0, "R6");
    chk("R6", "ea post-index", ea, model_ea(4'd13, 8'h08, pcr, xr, yr, er));
    run_op(4'd6, 8'h00, 8'h00, 1'b0, "R6");
    chk("R6", "ea pre-index", ea, model_ea(4'd6, 8'h00, pcr, xr, yr, er));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule